// File: doc/BRIEF.md
# Histogram Bin Calibration Unit

This unit converts raw fine-time bin numbers from a delay-line time-to-digital converter into calibrated times in picoseconds. Delay-line bins are unequal in width, so the unit measures them by code density. It counts how often each raw bin occurs over a collection run of 16384 valid hits that are spread evenly across one clock period. It then turns that histogram into a lookup table, where each bin maps to the picosecond position of its centre inside the 4000 ps period.

Each hit is translated through the active table one cycle after it arrives. Collection begins with a start pulse. When a run ends, the unit waits for its pipelined counting path to empty. It then scans the histogram once. During the scan it writes a fresh table into a second bank and clears the histogram. At the end of the scan the two banks swap and a new run begins without any further command. The calibration therefore keeps refreshing itself while the unit translates hits without pause.

Top module: `hist_cal_unit`

## Requirements
- R1: After reset, cal_valid is 0, and every bin k of the active table holds floor((2k+1)*4000/128), which is the centre of bin k when all 64 bins are equally wide.
- R2: A hit presented with hit_valid=1 gives cal_valid=1 exactly one clock later, with cal_ps equal to the active table entry for hit_bin, which is 6 bits wide and covers bins 0 to 63.
- R3: Hits that arrive before the first start pulse are translated but are not counted in the histogram.
- R4: After start, a collection run accepts exactly 16384 valid hits. The hit that completes the count ends the run.
- R5: Each accepted hit adds one to the histogram count of its bin through a read-modify-write pipeline. The count is correct even when the same bin is hit again 1, 2 or 3 cycles later.
- R6: The rebuilt entry for bin k equals floor((2*S_k + c_k)*4000/32768), where c_k is the count of bin k and S_k is the sum of the counts of all lower bins.
- R7: While the table is being rebuilt, hits are translated through the previous table. The new table takes effect only after the scan finishes.
- R8: Hits that arrive between the end of a run and the swap of the table are not counted. The histogram is empty when the next run starts automatically after the swap.
- R9: In a cycle that follows one with hit_valid=0, cal_valid is 0 and cal_ps is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle pulse that begins the first collection run |
| hit_valid | input | 1 | Qualifies hit_bin |
| hit_bin | input | 6 | Raw fine-time bin number |
| cal_valid | output | 1 | Calibrated time valid, one cycle after hit_valid |
| cal_ps | output | 12 | Calibrated time in picoseconds |

## Verification
The assertions assume that hit_bin always addresses one of the 64 bins and that no bin can collect more hits than a run contains, so every count and partial sum stays within 15 bits. They also assume that the histogram is cleared only after the counting pipeline has emptied. The stimulus stays within these limits: it sends a single start pulse, uses every 6-bit bin value, and leaves a quiet gap longer than the drain and scan before it relies on a new table. Hits sent during the rebuild window are used on purpose to show that they change nothing.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NBINS_D  = 64;
    localparam int CNT_W_D  = 15;
    localparam int EVENTS_D = 16384;
    localparam int PERIOD_D = 4000;
    localparam int PS_W_D   = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DRAIN,
        ST_SCAN
    } cal_state_e;

    // Centre of bin k when all bins share the period equally.
    function automatic int dflt_ps(input int k, input int nbins, input int period);
        return ((2 * k + 1) * period) / (2 * nbins);
    endfunction

endpackage

// File: rtl/cal_hist.sv
module cal_hist #(
    parameter int NBINS = cal_pkg::NBINS_D,
    parameter int CNT_W = cal_pkg::CNT_W_D,
    parameter int EVENTS = cal_pkg::EVENTS_D,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_v,
    input  logic [BIN_W-1:0] in_bin,
    input  logic             clr_en,
    input  logic [BIN_W-1:0] clr_bin,
    output logic [CNT_W-1:0] scan_cnt,
    output logic             busy
);

    typedef struct packed {
        logic             v;
        logic [BIN_W-1:0] bin;
        logic [CNT_W-1:0] cnt;
    } op_t;

    logic [CNT_W-1:0] mem [NBINS];
    logic             s0_v;
    logic [BIN_W-1:0] s0_bin;
    op_t              s1, s2, wb;
    logic [CNT_W-1:0] base;

    // Newest in-flight value for the bin wins over the stale RAM read.
    always_comb begin
        if (s2.v && s2.bin == s1.bin)
            base = s2.cnt;
        else if (wb.v && wb.bin == s1.bin)
            base = wb.cnt;
        else
            base = s1.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_v   <= 1'b0;
            s0_bin <= '0;
            s1     <= '0;
            s2     <= '0;
            wb     <= '0;
            for (int k = 0; k < NBINS; k++) mem[k] <= '0;
        end else begin
            s0_v   <= in_v;
            s0_bin <= in_bin;
            s1     <= '{v: s0_v, bin: s0_bin, cnt: mem[s0_bin]};
            s2     <= '{v: s1.v, bin: s1.bin, cnt: base + CNT_W'(1)};
            wb     <= s2;
            if (s2.v)
                mem[s2.bin] <= s2.cnt;
            else if (clr_en)
                mem[clr_bin] <= '0;
        end
    end

    assign scan_cnt = mem[clr_bin];
    assign busy     = s0_v | s1.v | s2.v;

    // R8: clearing only happens once the counting pipeline is empty
    p_clear_idle_r8: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> !busy);

    // R5: a written count is at least one and never above the run length
    p_write_range_r5: assert property (@(posedge clk) disable iff (rst)
        s2.v |-> (s2.cnt != '0 && s2.cnt <= CNT_W'(EVENTS)));

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl #(
    parameter int NBINS     = cal_pkg::NBINS_D,
    parameter int CNT_W     = cal_pkg::CNT_W_D,
    parameter int EVENTS    = cal_pkg::EVENTS_D,
    parameter int PERIOD_PS = cal_pkg::PERIOD_D,
    parameter int PS_W      = cal_pkg::PS_W_D,
    localparam int BIN_W = $clog2(NBINS),
    localparam int EV_W  = $clog2(EVENTS),
    localparam int SUM_W = CNT_W + 2,
    localparam int PRD_W = SUM_W + $clog2(PERIOD_PS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hit_valid,
    input  logic             hist_busy,
    input  logic [CNT_W-1:0] scan_cnt,
    output logic             acc,
    output logic             clr_en,
    output logic [BIN_W-1:0] scan_bin,
    output logic             tbl_we,
    output logic [PS_W-1:0]  tbl_wdata,
    output logic             swap
);
    import cal_pkg::*;

    cal_state_e        state;
    logic [EV_W-1:0]   ev_cnt;
    logic [BIN_W-1:0]  idx;
    logic [CNT_W:0]    cum;
    logic [SUM_W-1:0]  sum2;
    logic [PRD_W-1:0]  prod;

    assign acc      = hit_valid && (state == ST_COLLECT);
    assign clr_en   = (state == ST_SCAN);
    assign tbl_we   = (state == ST_SCAN);
    assign scan_bin = idx;
    assign swap     = (state == ST_SCAN) && (idx == BIN_W'(NBINS - 1));

    // Centre of the bin: twice the lower sum plus this bin's count.
    assign sum2      = {cum, 1'b0} + SUM_W'(scan_cnt);
    assign prod      = PRD_W'(sum2) * PRD_W'(PERIOD_PS);
    assign tbl_wdata = PS_W'(prod / PRD_W'(2 * EVENTS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ev_cnt <= '0;
            idx    <= '0;
            cum    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_COLLECT;
                        ev_cnt <= '0;
                    end
                end
                ST_COLLECT: begin
                    if (acc) begin
                        if (ev_cnt == EV_W'(EVENTS - 1)) begin
                            state  <= ST_DRAIN;
                            ev_cnt <= '0;
                        end else begin
                            ev_cnt <= ev_cnt + EV_W'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    if (!hist_busy) begin
                        state <= ST_SCAN;
                        idx   <= '0;
                        cum   <= '0;
                    end
                end
                ST_SCAN: begin
                    cum <= cum + (CNT_W + 1)'(scan_cnt);
                    idx <= idx + BIN_W'(1);
                    if (swap) state <= ST_COLLECT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: the histogram read during the scan holds exactly one run of hits
    p_sum_matches_r4: assert property (@(posedge clk) disable iff (rst)
        swap |-> ((cum + (CNT_W + 1)'(scan_cnt)) == (CNT_W + 1)'(EVENTS)));

    // R7: a new table takes effect only as the scan reaches its last bin
    p_swap_last_r7: assert property (@(posedge clk) disable iff (rst)
        swap |=> (state == ST_COLLECT));

endmodule

// File: rtl/cal_lut.sv
module cal_lut #(
    parameter int NBINS     = cal_pkg::NBINS_D,
    parameter int PERIOD_PS = cal_pkg::PERIOD_D,
    parameter int PS_W      = cal_pkg::PS_W_D,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [BIN_W-1:0] waddr,
    input  logic [PS_W-1:0]  wdata,
    input  logic             swap,
    input  logic             rd_v,
    input  logic [BIN_W-1:0] rd_bin,
    output logic             out_v,
    output logic [PS_W-1:0]  out_ps
);

    logic [PS_W-1:0] bank [2][NBINS];
    logic            act;

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= 1'b0;
            out_v  <= 1'b0;
            out_ps <= '0;
            for (int b = 0; b < 2; b++)
                for (int k = 0; k < NBINS; k++)
                    bank[b][k] <= PS_W'(cal_pkg::dflt_ps(k, NBINS, PERIOD_PS));
        end else begin
            if (we) bank[~act][waddr] <= wdata;
            if (swap) act <= ~act;
            out_v  <= rd_v;
            out_ps <= rd_v ? bank[act][rd_bin] : '0;
        end
    end

    // R6: a calibrated time never leaves the clock period
    p_out_range_r6: assert property (@(posedge clk) disable iff (rst)
        out_v |-> (out_ps <= PS_W'(PERIOD_PS)));

endmodule

// File: rtl/hist_cal_unit.sv
module hist_cal_unit #(
    parameter int NBINS     = cal_pkg::NBINS_D,
    parameter int CNT_W     = cal_pkg::CNT_W_D,
    parameter int EVENTS    = cal_pkg::EVENTS_D,
    parameter int PERIOD_PS = cal_pkg::PERIOD_D,
    parameter int PS_W      = cal_pkg::PS_W_D,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hit_valid,
    input  logic [BIN_W-1:0] hit_bin,
    output logic             cal_valid,
    output logic [PS_W-1:0]  cal_ps
);

    logic             acc, busy, clr_en, tbl_we, swap;
    logic [BIN_W-1:0] scan_bin;
    logic [CNT_W-1:0] scan_cnt;
    logic [PS_W-1:0]  tbl_wdata;

    cal_ctrl #(
        .NBINS(NBINS), .CNT_W(CNT_W), .EVENTS(EVENTS),
        .PERIOD_PS(PERIOD_PS), .PS_W(PS_W)
    ) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .hit_valid(hit_valid),
        .hist_busy(busy), .scan_cnt(scan_cnt), .acc(acc), .clr_en(clr_en),
        .scan_bin(scan_bin), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata), .swap(swap)
    );

    cal_hist #(.NBINS(NBINS), .CNT_W(CNT_W), .EVENTS(EVENTS)) hist_i (
        .clk(clk), .rst(rst), .in_v(acc), .in_bin(hit_bin),
        .clr_en(clr_en), .clr_bin(scan_bin), .scan_cnt(scan_cnt), .busy(busy)
    );

    cal_lut #(.NBINS(NBINS), .PERIOD_PS(PERIOD_PS), .PS_W(PS_W)) lut_i (
        .clk(clk), .rst(rst), .we(tbl_we), .waddr(scan_bin), .wdata(tbl_wdata),
        .swap(swap), .rd_v(hit_valid), .rd_bin(hit_bin),
        .out_v(cal_valid), .out_ps(cal_ps)
    );

    // R2: every hit is answered on the next cycle
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        hit_valid |=> cal_valid);

    // R9: no hit, no output
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |=> (!cal_valid && cal_ps == '0));

endmodule

// File: tb/hist_cal_unit_tb_top.sv
module hist_cal_unit_tb_top;

    localparam int NB  = 64;
    localparam int EV  = 16384;
    localparam int PER = 4000;
    localparam int NSEG = 8;
    // bin, run length, idle cycles after each hit
    localparam int SEG [NSEG][3] = '{
        '{5, 40, 0}, '{9, 30, 1}, '{9, 20, 2}, '{12, 24, 3},
        '{63, 16, 0}, '{0, 12, 1}, '{31, 50, 0}, '{47, 8, 2}
    };

    logic       clk = 1'b0;
    logic       rst, start, vi;
    logic [5:0] bi;
    logic       cal_valid;
    logic [11:0] cal_ps;

    int nchk = 0;
    int nerr = 0;
    int cnt [NB];
    int tab [NB];
    int ev;

    always #10 clk = ~clk;

    hist_cal_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .hit_valid(vi), .hit_bin(bi),
        .cal_valid(cal_valid), .cal_ps(cal_ps)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hit(input int bin, input string req);
        vi = 1'b1;
        bi = 6'(bin);
        @(negedge clk);
        check({req, " valid"}, int'(cal_valid), 1);
        check({req, " ps"}, int'(cal_ps), tab[bin]);
    endtask

    task automatic idle(input int n);
        vi = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic rebuild();
        int cum = 0;
        for (int k = 0; k < NB; k++) begin
            tab[k] = ((2 * cum + cnt[k]) * PER) / (2 * EV);
            cum += cnt[k];
            cnt[k] = 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; vi = 1'b0; bi = '0;
        for (int k = 0; k < NB; k++) begin
            cnt[k] = 0;
            tab[k] = ((2 * k + 1) * PER) / (2 * NB);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset valid", int'(cal_valid), 0);
        // R1/R2/R3: default table, hits before start are not counted
        for (int k = 0; k < NB; k++) hit(k, "R1");
        idle(1);
        check("R9 idle valid", int'(cal_valid), 0);
        check("R9 idle ps", int'(cal_ps), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // R4/R5: first run, same-bin hits at distances 1..4
        ev = 0;
        for (int s = 0; s < NSEG; s++) begin
            for (int r = 0; r < SEG[s][1]; r++) begin
                hit(SEG[s][0], "R5");
                cnt[SEG[s][0]]++;
                ev++;
                if (SEG[s][2] > 0) idle(SEG[s][2]);
            end
        end
        while (ev < EV) begin
            int b = ((ev * ev) / 7 + ev) % NB;
            hit(b, "R4");
            cnt[b]++;
            ev++;
        end
        // R7/R8: hits during drain and scan use the old table and are not counted
        for (int j = 0; j < 40; j++) hit((j * 11 + 3) % NB, "R7");
        idle(100);
        rebuild();

        // R6: new table, these hits open the second run
        for (int k = 0; k < NB; k++) begin
            hit(k, "R6");
            cnt[k]++;
        end
        ev = NB;
        // R8: second run starts from a cleared histogram
        while (ev < EV) begin
            int b = (ev % 3 == 0) ? 40 : ((ev % 5) + 17);
            hit(b, "R8");
            cnt[b]++;
            ev++;
        end
        idle(100);
        rebuild();
        for (int k = 0; k < NB; k++) hit(k, "R8 second table");
        idle(1);
        check("R9 final idle", int'(cal_valid), 0);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule